// File: doc/BRIEF.md
# Four-Channel Event Timer with Shared Tick-Base Selection

This block holds four independent 16-bit countdown channels and one 32-bit free-running timestamp counter behind a small word-addressed register bus. A single prescaler turns the system clock into strobes at 1 µs, 10 µs, 100 µs and 1 ms. Each countdown channel picks one of these as its step rate, and so does the timestamp counter, which can also step on every system clock. One shared control word holds every channel's run bit, its repeat bit and its step-rate code, plus the step-rate code of the timestamp counter.

Software writes a reload value N into a channel and then sets that channel's run bit. The channel counts down from N once per selected strobe and expires on the strobe that finds it at zero, so a period is N+1 strobes long. On expiry it emits a one-cycle interrupt pulse. In repeat mode it reloads N and carries on. In single-shot mode it stops and the block clears the channel's run bit. The timestamp counter may be read at any time and ignores writes.

Top module: `multi_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word and all four channel registers read 0, and every interrupt output is low.
- R2: The word offset `reg_addr[4:2]` selects the register: 0 the control word, 1 to 4 channels 0 to 3, and 5 the timestamp. In the control word, bit 16+i is channel i's run bit, bit 12+i its repeat bit (1 = repeat, 0 = single-shot), bits [2i+1:2i] its step-rate code, and bits [10:8] the timestamp step-rate code. Bit 11 and bits 31:20 read as 0 whatever is written.
- R3: With CYC_PER_US system clocks per microsecond, channel step-rate codes 0, 1, 2 and 3 select strobes every 1, 10, 100 and 1000 µs.
- R4: A running repeat-mode channel loaded with N pulses its interrupt for exactly one cycle every (N+1) strobes of its selected rate.
- R5: A single-shot channel pulses its interrupt once, then clears its own run bit in the control word, holds a count of 0 and raises no further pulse.
- R6: Clearing a channel's run bit stops it: no interrupt pulse follows while the bit stays clear.
- R7: Writing a channel register loads bits [15:0] as its reload value and current count; a read returns the current count in bits [15:0] with bits [31:16] at 0.
- R8: The timestamp counter adds one per system clock for code 0, and per 1 µs, 10 µs, 100 µs or 1 ms strobe for codes 1, 2, 3 or 4; codes 5 to 7 hold it still.
- R9: A write to the timestamp offset leaves the timestamp value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus, one cycle per write |
| reg_addr | input | 5 | Byte address; bits [4:2] pick the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 4 | One-cycle expiry pulse per countdown channel |

## Verification
A wrong count, reload or strobe phase inside a channel shows at the ports as an interrupt spacing that differs from (N+1) strobe periods. This appears by the second pulse of a repeat run, within at most two periods. A stuck run bit or a missing single-shot stop shows up in the control readback and as a stray pulse one period after the first. Prescaler or timestamp faults show as a timestamp delta over a fixed window that differs from the window divided by the strobe period, after a single window.

// File: rtl/tm_pkg.sv
// Package: shared constants and types of the multi-channel timer.
// Assumes word-aligned register access; offsets are word indices.
package tm_pkg;
    localparam int NUM_CH   = 4;
    localparam int CNT_W    = 16;
    localparam int STAMP_W  = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;

    // Word index of each register (reg_addr[4:2])
    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_CH0   = 3'd1;
    localparam logic [2:0] IDX_STAMP = 3'd5;

    // Control word field positions
    localparam int RUN_LSB    = 16;
    localparam int REPEAT_LSB = 12;
    localparam int SBASE_LSB  = 8;
    localparam int SBASE_W    = 3;
    localparam int RATE_W     = 2;

    // Bits that hold state in the control word
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h000F_F7FF;

    // Strobes from the prescaler, one cycle wide each
    typedef struct packed {
        logic ms1;
        logic us100;
        logic us10;
        logic us1;
    } tick_bus_t;

    // Timestamp step-rate codes
    typedef enum logic [SBASE_W-1:0] {
        SB_SYSCLK = 3'd0,
        SB_1US    = 3'd1,
        SB_10US   = 3'd2,
        SB_100US  = 3'd3,
        SB_1MS    = 3'd4
    } stamp_base_e;
endpackage

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Divides the system clock into strobes every 1 us, 10 us, 100 us and 1 ms.
// Assumes CYC_PER_US >= 1 system clocks per microsecond. The decade stages are
// cascaded, so every slower strobe coincides with a 1 us strobe.
module tick_prescaler
    import tm_pkg::*;
#(
    parameter int CYC_PER_US = 24
) (
    input  logic      clk,
    input  logic      rst_n,
    output tick_bus_t ticks
);
    localparam int CYC_W    = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int N_DEC    = 3;
    localparam int DEC_W    = 4;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);

    logic [CYC_W-1:0] cyc_cnt;
    logic             us_strobe;
    logic [DEC_W-1:0] dec_cnt [N_DEC];
    logic [N_DEC:0]   stage_strobe;

    assign us_strobe       = (cyc_cnt == CYC_LAST);
    assign stage_strobe[0] = us_strobe;

    // Purpose: count system clocks within one microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_cnt <= '0;
        else if (us_strobe)  cyc_cnt <= '0;
        else                 cyc_cnt <= cyc_cnt + 1'b1;
    end

    for (genvar s = 0; s < N_DEC; s++) begin : g_decade
        assign stage_strobe[s+1] = stage_strobe[s] && (dec_cnt[s] == DEC_W'(9));

        // Purpose: count ten strobes of the faster stage.
        always_ff @(posedge clk) begin
            if (!rst_n)                 dec_cnt[s] <= '0;
            else if (stage_strobe[s+1]) dec_cnt[s] <= '0;
            else if (stage_strobe[s])   dec_cnt[s] <= dec_cnt[s] + 1'b1;
        end
    end

    assign ticks.us1   = stage_strobe[0];
    assign ticks.us10  = stage_strobe[1];
    assign ticks.us100 = stage_strobe[2];
    assign ticks.ms1   = stage_strobe[3];

    // Checker state: clocks since the last 1 us strobe.
    logic [31:0] gap_cnt;
    logic        gap_valid;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt   <= '0;
            gap_valid <= 1'b0;
        end else if (ticks.us1) begin
            gap_cnt   <= '0;
            gap_valid <= 1'b1;
        end else begin
            gap_cnt   <= gap_cnt + 1;
        end
    end

    // R3
    us_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks.us1 && gap_valid) |-> (gap_cnt == 32'(CYC_PER_US - 1)));
endmodule

// File: rtl/event_channel.sv
// Module: event_channel
// One countdown channel. Loads a reload value, counts down once per tick
// while running and expires on the tick that finds zero: N+1 ticks per period.
// Assumes 'tick' is a one-cycle strobe. A rising 'run' restarts from reload.
module event_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             repeat_mode,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             done
);
    logic [CNT_W-1:0] reload;
    logic             run_d;
    logic             spent;
    logic             start;
    logic             expire;

    assign start  = run && !run_d;
    assign expire = run && !start && !load_we && tick && !spent && (count == '0);
    assign done   = expire && !repeat_mode;

    // Purpose: remember the run bit to detect a fresh start.
    always_ff @(posedge clk) begin
        if (!rst_n) run_d <= 1'b0;
        else        run_d <= run;
    end

    // Purpose: turn an expiry into a one-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= expire;
    end

    // Purpose: reload, countdown and single-shot stop of the channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
            count  <= '0;
            spent  <= 1'b0;
        end else if (load_we) begin
            reload <= load_val;
            count  <= load_val;
            spent  <= 1'b0;
        end else if (start) begin
            count  <= reload;
            spent  <= 1'b0;
        end else if (expire) begin
            if (repeat_mode) count <= reload;
            else             spent <= 1'b1;
        end else if (run && tick && !spent) begin
            count  <= count - 1'b1;
        end
    end

    // R4
    count_le_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= reload);

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we && !start) |=> $stable(count));

    // R5
    spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spent && !start && !load_we) |=> !irq);
endmodule

// File: rtl/stamp_counter.sv
// Module: stamp_counter
// Free-running timestamp counter. Steps on the strobe picked by a 3-bit code;
// codes above the 1 ms code hold it. Never written by software.
module stamp_counter
    import tm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tick_bus_t          ticks,
    input  logic [SBASE_W-1:0] base_sel,
    output logic [WIDTH-1:0]   stamp
);
    logic step;

    // Purpose: pick the step strobe for the selected code.
    always_comb begin
        case (base_sel)
            SB_SYSCLK: step = 1'b1;
            SB_1US:    step = ticks.us1;
            SB_10US:   step = ticks.us10;
            SB_100US:  step = ticks.us100;
            SB_1MS:    step = ticks.ms1;
            default:   step = 1'b0;
        endcase
    end

    // Purpose: advance the timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n)    stamp <= '0;
        else if (step) stamp <= stamp + 1'b1;
    end

    // R8
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_sel > SBASE_W'(4)) |=> $stable(stamp));

    // R8
    stamp_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_sel == SBASE_W'(0)) |=> (stamp == $past(stamp) + 1'b1));
endmodule

// File: rtl/multi_tick_timer.sv
// Module: multi_tick_timer (top)
// Register decode, shared control word, prescaler, four countdown channels
// and the timestamp counter. Assumes single-cycle write strobes and a
// combinational read path; reg_addr[1:0] are ignored.
module multi_tick_timer
    import tm_pkg::*;
#(
    parameter int CYC_PER_US = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   word_idx;
    logic [DATA_W-1:0]  ctrl;
    tick_bus_t          ticks;
    logic [NUM_CH-1:0]  ch_done;
    logic [NUM_CH-1:0]  ch_load;
    logic [NUM_CH-1:0]  ch_tick;
    logic [CNT_W-1:0]   ch_count [NUM_CH];
    logic [STAMP_W-1:0] stamp;
    logic               ctrl_we;

    assign word_idx = reg_addr[ADDR_W-1:2];
    assign ctrl_we  = reg_wr && (word_idx == IDX_CTRL);

    tick_prescaler #(.CYC_PER_US(CYC_PER_US)) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .ticks (ticks)
    );

    // Purpose: hold the control word; software writes win over self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl <= reg_wdata & CTRL_MASK;
        end else begin
            for (int i = 0; i < NUM_CH; i++)
                if (ch_done[i]) ctrl[RUN_LSB+i] <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [RATE_W-1:0] rate;
        assign rate       = ctrl[RATE_W*i +: RATE_W];
        assign ch_load[i] = reg_wr && (word_idx == IDX_W'(IDX_CH0 + 3'(i)));

        // Purpose: route the selected strobe to this channel.
        always_comb begin
            case (rate)
                2'd0:    ch_tick[i] = ticks.us1;
                2'd1:    ch_tick[i] = ticks.us10;
                2'd2:    ch_tick[i] = ticks.us100;
                default: ch_tick[i] = ticks.ms1;
            endcase
        end

        event_channel #(.CNT_W(CNT_W)) u_channel (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (ch_tick[i]),
            .run         (ctrl[RUN_LSB+i]),
            .repeat_mode (ctrl[REPEAT_LSB+i]),
            .load_we     (ch_load[i]),
            .load_val    (reg_wdata[CNT_W-1:0]),
            .count       (ch_count[i]),
            .irq         (irq[i]),
            .done        (ch_done[i])
        );

        // R5
        oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[i] && !ctrl_we) |=> !ctrl[RUN_LSB+i]);

        // R6
        stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[RUN_LSB+i] && !ctrl_we) |=> !irq[i]);
    end

    stamp_counter #(.WIDTH(STAMP_W)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ticks    (ticks),
        .base_sel (ctrl[SBASE_LSB +: SBASE_W]),
        .stamp    (stamp)
    );

    // Purpose: combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (word_idx)
            IDX_W'(0): reg_rdata = ctrl;
            IDX_W'(1): reg_rdata = DATA_W'(ch_count[0]);
            IDX_W'(2): reg_rdata = DATA_W'(ch_count[1]);
            IDX_W'(3): reg_rdata = DATA_W'(ch_count[2]);
            IDX_W'(4): reg_rdata = DATA_W'(ch_count[3]);
            IDX_W'(5): reg_rdata = DATA_W'(stamp);
            default:   reg_rdata = '0;
        endcase
    end

    // R2
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & ~CTRL_MASK) == '0);
endmodule

// File: tb/test_multi_tick_timer.sv
module test_multi_tick_timer;
    localparam int CPU = 2;                 // clocks per microsecond in the bench
    localparam int NV  = 6;
    localparam int V_CH  [NV] = '{0, 1, 2, 3, 0, 2};
    localparam int V_RATE[NV] = '{0, 1, 2, 3, 1, 0};
    localparam int V_N   [NV] = '{4, 2, 1, 0, 9, 1};
    localparam int V_PER [NV] = '{10, 60, 400, 2000, 200, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    multi_tick_timer #(.CYC_PER_US(CPU)) i_multi_tick_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(idx * 4); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        reg_addr = 5'(idx * 4);
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input int ch, input int limit, output bit seen, output int t);
        seen = 1'b0; t = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (irq[ch]) begin seen = 1'b1; t = cyc; break; end
        end
    endtask

    task automatic count_irq(input int ch, input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq[ch]) hits++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        bit seen;
        int t1, t2, hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
        for (int c = 1; c <= 4; c++) begin
            rd(c, v); chk(v == 0, "R1 count", v, 0);
        end
        chk(irq == 0, "R1 irq", irq, 0);

        // R2: control readback mask
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); chk(v == 32'h000F_F7FF, "R2 mask", v, 32'h000F_F7FF);
        wr(0, 32'h0);
        rd(0, v); chk(v == 0, "R2 clear", v, 0);

        // R7: channel load and readback
        wr(2, 32'hABCD_1234);
        rd(2, v); chk(v == 32'h0000_1234, "R7 load", v, 32'h1234);

        // R3/R4: vector table, repeat mode period and pulse width
        for (int i = 0; i < NV; i++) begin
            int ch = V_CH[i];
            logic [31:0] cw;
            cw = (32'd1 << (16 + ch)) | (32'd1 << (12 + ch)) | (32'(V_RATE[i]) << (2 * ch));
            wr(ch + 1, 32'(V_N[i]));
            wr(0, cw);
            wait_irq(ch, 3 * V_PER[i] + 50, seen, t1);
            @(negedge clk);
            chk(irq[ch] == 1'b0, "R4 pulse width", irq[ch], 0);
            wait_irq(ch, 3 * V_PER[i] + 50, seen, t2);
            chk(seen && (t2 - t1 == V_PER[i]), "R3/R4 period", t2 - t1, V_PER[i]);
            wr(0, 32'h0);
        end

        // R5: single-shot stops and clears its run bit
        wr(4, 32'd3);
        wr(0, 32'h0004_0000);                       // channel 2, rate 1 us, single-shot
        wait_irq(2, 100, seen, t1);
        chk(seen, "R5 first pulse", seen, 1);
        repeat (2) @(negedge clk);
        rd(0, v); chk(v[18] == 1'b0, "R5 run cleared", v[18], 0);
        rd(3, v); chk(v == 0, "R5 count zero", v, 0);
        count_irq(2, 100, hits); chk(hits == 0, "R5 no repeat", hits, 0);

        // R6: clearing the run bit stops a repeat channel
        wr(1, 32'd2);
        wr(0, 32'h0001_1000);
        wait_irq(0, 100, seen, t1);
        wr(0, 32'h0);
        count_irq(0, 60, hits); chk(hits == 0, "R6 stopped", hits, 0);

        // R8: timestamp rates
        wr(0, 32'h0000_0000);
        rd(5, v); repeat (50) @(negedge clk); rd(5, v2);
        chk(v2 - v == 50, "R8 sysclk", v2 - v, 50);
        wr(0, 32'h0000_0100);
        rd(5, v); repeat (200) @(negedge clk); rd(5, v2);
        chk(v2 - v == 100, "R8 1us", v2 - v, 100);
        wr(0, 32'h0000_0200);
        rd(5, v); repeat (2000) @(negedge clk); rd(5, v2);
        chk(v2 - v == 100, "R8 10us", v2 - v, 100);
        wr(0, 32'h0000_0400);
        rd(5, v); repeat (4000) @(negedge clk); rd(5, v2);
        chk(v2 - v == 2, "R8 1ms", v2 - v, 2);
        wr(0, 32'h0000_0700);
        rd(5, v); repeat (100) @(negedge clk); rd(5, v2);
        chk(v2 == v, "R8 hold", v2, v);

        // R9: timestamp write ignored
        wr(5, 32'h0000_1234);
        rd(5, v2); chk(v2 == v, "R9 write ignored", v2, v);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule